// File: doc/BRIEF.md
# Paged Logical-to-Physical Address Translator

This block is the page-mapping part of a memory controller. Physical RAM is split into 128 pages. The block holds one slot for each physical page, and each slot names the logical page that sits on top of it. Software programs a slot with a single write cycle into the translator zone. The write address carries the whole entry: its low seven bits pick the slot, and its upper bits carry the logical page number.

A separate configuration write picks one of four page sizes: 4, 8, 16 or 32 KB. The page size decides how the bits of a slot's programming word are read as a physical page number and as a logical page number. Slots keep their raw programming bits, so changing the page size reinterprets every entry at once, with no reprogramming.

A lookup presents a 25-bit logical address. The block compares its logical page against every valid slot in the same cycle. One cycle later it returns a hit flag and a 22-bit physical address, formed from the winning slot's physical page and the in-page offset.

Top module: `page_xlat`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses. The page size is 4 KB, and `rsp_valid` and `rsp_hit` are 0.
- R2: A cycle with `cfg_we` high loads the page size from `wr_addr[3:2]`: 0 selects 4 KB, 1 selects 8 KB, 2 selects 16 KB and 3 selects 32 KB.
- R3: A cycle with `map_we` high writes slot `wr_addr[6:0]` and marks it valid. A later write to the same slot replaces the earlier entry completely.
- R4: At 4 KB the slot's physical page is `wr_addr[6:0]` and its logical page is {`wr_addr[11:10]`, `wr_addr[22:12]`}. The logical page of a lookup is `lk_addr[24:12]`.
- R5: At 8 KB the physical page is {A[0], A[6:1]} and the logical page is {A[11:10], A[22:13]}, where A is the slot's write address. The logical page of a lookup is `lk_addr[24:13]`.
- R6: At 16 KB the physical page is {A[1:0], A[6:2]} and the logical page is {A[11:10], A[22:14]}. The logical page of a lookup is `lk_addr[24:14]`.
- R7: At 32 KB the physical page is {A[1], A[2], A[0], A[6:3]} and the logical page is {A[11:10], A[22:15]}. The logical page of a lookup is `lk_addr[24:15]`.
- R8: A lookup strobed by `lk_req` gives `rsp_valid` high in the next cycle and low otherwise. On a hit, `rsp_paddr` equals the physical page times the page size plus the in-page offset of `lk_addr`.
- R9: A lookup whose logical page matches no valid slot gives `rsp_hit` low and `rsp_paddr` zero.
- R10: When several valid slots hold the same logical page, the slot with the lowest index supplies the physical page. This holds at every page size.
- R11: A lookup in the same cycle as a slot write or a page-size write uses the old slots and the old page size.
- R12: A page-size change reinterprets the slots already written, with no rewrite.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Page-size configuration write strobe |
| map_we | input | 1 | Translator slot write strobe |
| wr_addr | input | 23 | Write address carrying the page size or the slot entry |
| lk_req | input | 1 | Lookup strobe |
| lk_addr | input | 25 | Logical address to translate |
| rsp_valid | output | 1 | Lookup result valid, one cycle after `lk_req` |
| rsp_hit | output | 1 | Lookup found a valid matching slot |
| rsp_paddr | output | 22 | Translated physical address, zero on a miss |

## Verification
A corrupted slot or a wrong page-size register shows up on the very next lookup that touches it, one cycle after the strobe. It appears as the wrong hit flag or as a physical address whose page bits are scrambled in the pattern of another page size. A broken priority choice only shows when two slots share a logical page, so duplicates are programmed deliberately at every page size, with the lower slot index written last. Same-cycle write and lookup cases pin down which edge a new entry or a new page size becomes visible on.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    localparam int PPN_W      = 7;
    localparam int NUM_SLOTS  = 1 << PPN_W;
    localparam int SEL_W      = $clog2(NUM_SLOTS);
    localparam int BASE_SHIFT = 12;
    localparam int LPN_W      = 13;
    localparam int LA_W       = LPN_W + BASE_SHIFT;
    localparam int PA_W       = PPN_W + BASE_SHIFT + 3;
    localparam int WA_W       = 23;
    localparam int HI_W       = WA_W - BASE_SHIFT;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_8K  = 2'd1,
        PG_16K = 2'd2,
        PG_32K = 2'd3
    } pg_size_e;

    // raw slot word: {A[22:12], A[11:10]}
    typedef struct packed {
        logic             valid;
        logic [LPN_W-1:0] raw;
    } slot_t;

    // physical page from a slot index, scattered per page size
    function automatic logic [PPN_W-1:0] slot_ppn(logic [PPN_W-1:0] idx, pg_size_e ps);
        logic [PPN_W-1:0] r;
        case (ps)
            PG_4K:   r = idx;
            PG_8K:   r = {idx[0], idx[6:1]};
            PG_16K:  r = {idx[1:0], idx[6:2]};
            default: r = {idx[1], idx[2], idx[0], idx[6:3]};
        endcase
        return r;
    endfunction

    // logical page held by a slot, zero-extended
    function automatic logic [LPN_W-1:0] slot_lpn(logic [LPN_W-1:0] raw, pg_size_e ps);
        logic [HI_W-1:0] hi;
        logic [1:0]      mid;
        logic [LPN_W-1:0] r;
        hi  = raw[LPN_W-1:2];
        mid = raw[1:0];
        case (ps)
            PG_4K:   r = {mid, hi};
            PG_8K:   r = {1'b0, mid, hi[HI_W-1:1]};
            PG_16K:  r = {2'b0, mid, hi[HI_W-1:2]};
            default: r = {3'b0, mid, hi[HI_W-1:3]};
        endcase
        return r;
    endfunction

    // logical page of a lookup address, zero-extended
    function automatic logic [LPN_W-1:0] addr_lpn(logic [LA_W-1:0] la, pg_size_e ps);
        logic [LPN_W-1:0] r;
        case (ps)
            PG_4K:   r = la[LA_W-1:BASE_SHIFT];
            PG_8K:   r = {1'b0, la[LA_W-1:BASE_SHIFT+1]};
            PG_16K:  r = {2'b0, la[LA_W-1:BASE_SHIFT+2]};
            default: r = {3'b0, la[LA_W-1:BASE_SHIFT+3]};
        endcase
        return r;
    endfunction

    // physical page glued to the in-page offset
    function automatic logic [PA_W-1:0] make_paddr(logic [PPN_W-1:0] ppn,
                                                   logic [LA_W-1:0] la, pg_size_e ps);
        logic [PA_W-1:0] r;
        case (ps)
            PG_4K:   r = {3'b0, ppn, la[BASE_SHIFT-1:0]};
            PG_8K:   r = {2'b0, ppn, la[BASE_SHIFT:0]};
            PG_16K:  r = {1'b0, ppn, la[BASE_SHIFT+1:0]};
            default: r = {ppn, la[BASE_SHIFT+2:0]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pxl_slot.sv
module pxl_slot
    import pxl_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PPN_W-1:0] wr_idx,
    input  logic [LPN_W-1:0] wr_raw,
    input  pg_size_e         psize,
    input  logic [LPN_W-1:0] look_lpn,
    output logic             match
);
    localparam logic [PPN_W-1:0] MY_IDX = PPN_W'(IDX);

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_en && (wr_idx == MY_IDX)) begin
            slot_d.valid = 1'b1;          // R3
            slot_d.raw   = wr_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;         // R1
        else        slot_q <= slot_d;
    end

    // R12: decode against the live page size on every compare
    assign match = slot_q.valid && (slot_lpn(slot_q.raw, psize) == look_lpn);

endmodule

// File: rtl/pxl_pick.sv
module pxl_pick #(
    parameter int N = 128,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] sel
);
    // R10: lowest index wins, so scan downward and let the last hit stand
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                sel = IW'(i);
            end
        end
    end

endmodule

// File: rtl/page_xlat.sv
module page_xlat
    import pxl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            map_we,
    input  logic [WA_W-1:0] wr_addr,
    input  logic            lk_req,
    input  logic [LA_W-1:0] lk_addr,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [PA_W-1:0] rsp_paddr
);
    typedef struct packed {
        pg_size_e        psize;
        logic            rsp_valid;
        logic            rsp_hit;
        logic [PA_W-1:0] paddr;
    } top_t;

    top_t st_d, st_q;

    logic [LPN_W-1:0]     look_lpn;
    logic [NUM_SLOTS-1:0] hits;
    logic                 any_hit;
    logic [SEL_W-1:0]     win_idx;
    logic [LPN_W-1:0]     wr_raw;
    logic                 unused_wr_bits;

    assign unused_wr_bits = ^{wr_addr[9:7]};
    assign wr_raw   = {wr_addr[WA_W-1:BASE_SHIFT], wr_addr[11:10]};
    assign look_lpn = addr_lpn(lk_addr, st_q.psize);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        pxl_slot #(.IDX(g)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (map_we),
            .wr_idx   (wr_addr[PPN_W-1:0]),
            .wr_raw   (wr_raw),
            .psize    (st_q.psize),
            .look_lpn (look_lpn),
            .match    (hits[g])
        );
    end

    pxl_pick #(.N(NUM_SLOTS)) u_pick (
        .hits (hits),
        .any  (any_hit),
        .sel  (win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.psize = pg_size_e'(wr_addr[3:2]);   // R2
        // R11: compare uses registered slots and size, so writes land later
        st_d.rsp_valid = lk_req;                              // R8
        st_d.rsp_hit   = lk_req && any_hit;
        st_d.paddr     = '0;                                  // R9
        if (lk_req && any_hit)
            st_d.paddr = make_paddr(slot_ppn(win_idx, st_q.psize), lk_addr, st_q.psize);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.psize     <= PG_4K;                          // R1
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_hit   <= 1'b0;
            st_q.paddr     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_paddr = st_q.paddr;

endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk
    import pxl_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            map_we,
    input logic [WA_W-1:0] wr_addr,
    input logic            lk_req,
    input logic [LA_W-1:0] lk_addr,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [PA_W-1:0] rsp_paddr
);
    logic seen_map_q;
    logic unused_chk;

    assign unused_chk = ^{cfg_we, wr_addr};

    always_ff @(posedge clk) begin
        if (!rst_n)      seen_map_q <= 1'b0;
        else if (map_we) seen_map_q <= 1'b1;
    end

    p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && !rsp_hit));

    p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[BASE_SHIFT-1:0] == $past(lk_addr[BASE_SHIFT-1:0])));

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));

    p_empty_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_map_q |-> !rsp_hit);

endmodule

bind page_xlat page_xlat_chk u_chk (.*);

// File: tb/page_xlat_test.sv
`timescale 1ns/1ps
module page_xlat_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        map_we = 1'b0;
    logic [22:0] wr_addr = '0;
    logic        lk_req = 1'b0;
    logic [24:0] lk_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [21:0] rsp_paddr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    page_xlat uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // inverse encoding of the slot word, built from R4..R7
    function automatic logic [22:0] mk_addr(input int ps, input logic [6:0] ppn,
                                            input logic [12:0] lpn);
        logic [22:0] a = '0;
        case (ps)
            0: begin a[6:0] = ppn; a[11:10] = lpn[12:11]; a[22:12] = lpn[10:0]; end
            1: begin a[0] = ppn[6]; a[6:1] = ppn[5:0]; a[11:10] = lpn[11:10]; a[22:13] = lpn[9:0]; end
            2: begin a[1:0] = ppn[6:5]; a[6:2] = ppn[4:0]; a[11:10] = lpn[10:9]; a[22:14] = lpn[8:0]; end
            default: begin
                a[1] = ppn[6]; a[2] = ppn[5]; a[0] = ppn[4]; a[6:3] = ppn[3:0];
                a[11:10] = lpn[9:8]; a[22:15] = lpn[7:0];
            end
        endcase
        return a;
    endfunction

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_size(input int ps);
        @(negedge clk); cfg_we = 1'b1; wr_addr = 23'(ps) << 2;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic map(input logic [22:0] a);
        @(negedge clk); map_we = 1'b1; wr_addr = a;
        @(negedge clk); map_we = 1'b0;
    endtask

    task automatic look(input string tag, input logic [24:0] la,
                        input logic hit, input logic [21:0] pa);
        @(negedge clk); lk_req = 1'b1; lk_addr = la;
        @(negedge clk); lk_req = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " hit"},   32'(rsp_hit),   32'(hit));
        check({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
    endtask

    // R1: reset state, empty table, default 4 KB
    task automatic t_reset;
        do_reset();
        @(negedge clk);
        check("R1 idle valid", 32'(rsp_valid), 32'd0);
        check("R1 idle hit",   32'(rsp_hit),   32'd0);
        look("R1 empty", 25'h0, 1'b0, 22'h0);
        look("R1 empty high", 25'h1FF_F123, 1'b0, 22'h0);
        set_size(3);
        map(mk_addr(3, 7'h12, 13'h021));
        do_reset();
        look("R1 cleared", 25'(13'h021) << 15, 1'b0, 22'h0);
        map(mk_addr(0, 7'h12, 13'h021));
        look("R1 default 4K", (25'(13'h021) << 12) | 25'h7, 1'b1, (22'(7'h12) << 12) | 22'h7);
    endtask

    // R2, R4, R5, R6, R7, R8, R9: decode per page size
    task automatic t_size(input int ps);
        int sh = 12 + ps;
        string tg = $sformatf("R%0d", 4 + ps);
        logic [24:0] off_max = (25'd1 << sh) - 25'd1;
        do_reset();
        set_size(ps);
        map(mk_addr(ps, 7'h11, 13'h03C));
        map(mk_addr(ps, 7'h7F, 13'h1F0));
        look({tg, " R2 R8 first"}, (25'(13'h03C) << sh) | 25'h5,
             1'b1, (22'(7'h11) << sh) | 22'h5);
        look({tg, " R8 top offset"}, (25'(13'h1F0) << sh) | off_max,
             1'b1, (22'(7'h7F) << sh) | 22'(off_max));
        look({tg, " R9 miss"}, 25'(13'h002) << sh, 1'b0, 22'h0);
    endtask

    // R10: duplicate logical page, lowest slot wins
    task automatic t_dup(input int ps);
        int sh = 12 + ps;
        logic [22:0] a1 = mk_addr(ps, 7'h40, 13'h055);
        logic [22:0] a2 = mk_addr(ps, 7'h03, 13'h055);
        logic [6:0] win = (a1[6:0] < a2[6:0]) ? 7'h40 : 7'h03;
        do_reset();
        set_size(ps);
        if (a1[6:0] < a2[6:0]) begin map(a2); map(a1); end
        else begin map(a1); map(a2); end
        look($sformatf("R10 size%0d", ps), (25'(13'h055) << sh) | 25'h3,
             1'b1, (22'(win) << sh) | 22'h3);
    endtask

    // R3: rewriting a slot replaces its entry
    task automatic t_overwrite;
        do_reset();
        map(mk_addr(0, 7'h09, 13'h100));
        map(mk_addr(0, 7'h09, 13'h200));
        look("R3 old gone", 25'(13'h100) << 12, 1'b0, 22'h0);
        look("R3 new", (25'(13'h200) << 12) | 25'hABC, 1'b1, 22'h09ABC);
    endtask

    // R11: same-cycle write and lookup see the old state
    task automatic t_same_cycle;
        do_reset();
        @(negedge clk);
        map_we = 1'b1; wr_addr = mk_addr(0, 7'h22, 13'h044);
        lk_req = 1'b1; lk_addr = 25'h044000;
        @(negedge clk);
        map_we = 1'b0; lk_req = 1'b0;
        check("R11 map same cycle hit", 32'(rsp_hit), 32'd0);
        look("R11 map visible", 25'h044010, 1'b1, 22'h022010);
        @(negedge clk);
        cfg_we = 1'b1; wr_addr = 23'd1 << 2;
        lk_req = 1'b1; lk_addr = 25'h045010;
        @(negedge clk);
        cfg_we = 1'b0; lk_req = 1'b0;
        check("R11 cfg same cycle hit", 32'(rsp_hit), 32'd0);
        look("R11 cfg visible 8K", 25'h045010, 1'b1, 22'h023010);
    endtask

    // R12: page-size change reinterprets stored slots
    task automatic t_remap;
        do_reset();
        map(23'h0A0405);
        look("R12 at 4K", 25'h8A0123, 1'b1, 22'h005123);
        set_size(3);
        look("R12 at 32K", 25'h8A0123, 1'b1, 22'h180123);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        t_reset();
        for (int ps = 0; ps < 4; ps++) t_size(ps);
        for (int ps = 0; ps < 4; ps++) t_dup(ps);
        t_overwrite();
        t_same_cycle();
        t_remap();
        report();
    end

endmodule